// File: doc/BRIEF.md
# Set Replacement Victim Selector

This block picks which way of an N-way set-associative cache is filled when an access misses. It holds replacement state for every set and nothing else: tags, data, tag comparison and memory traffic stay with the surrounding cache. Each access presents a set index, a hit flag and, on a hit, the way that hit. On a miss the block returns the way to fill in the same cycle and updates that set's state at the next clock edge.

Three policies can be selected at run time. In LRU mode the victim is the least recently used way of a full recency list. In FIFO mode it is a per-set round-robin pointer. In random mode it comes from a reproducible LFSR. All state is kept up to date whichever policy is active, so a policy switch takes effect on the next miss and loses no history.

Top module: `victim_selector`

## Requirements
- R1: After synchronous reset every set's recency list is (0,1,...,N-1), with way 0 most recent and way N-1 least recent. Every FIFO pointer is 0. The LFSR state is 16'hACE1.
- R2: `victim_valid` is high exactly in cycles where `acc_valid` is 1 and `acc_hit` is 0. In that cycle `victim_way` gives the fill way, computed from the state held before the clock edge.
- R3: A hit on way w moves w to the most recent position of its set's list, and the other ways keep their relative order. For example, (0,1,2,3) followed by a hit on 2 gives (2,0,1,3).
- R4: With policy LRU, a miss returns the least recent way. Under every policy, the way returned on a miss moves to the most recent position. For example, (1,2,0,3) followed by a miss returns 3 and gives (3,1,2,0).
- R5: A hit on the way that is already most recent leaves the list unchanged.
- R6: With policy FIFO, a miss returns the set's pointer. Every miss to a set, under any policy, increments that set's pointer modulo N. Hits leave the pointer unchanged.
- R7: With policy RANDOM, a miss returns the low log2(N) bits of the 16-bit LFSR. The LFSR advances once per miss, under any policy, as a right-shifting Galois register: if the low bit is 1, the next state is (s>>1)^16'hB400, otherwise it is s>>1.
- R8: The `policy` encoding is 2'b00 LRU, 2'b01 FIFO, 2'b10 RANDOM, and 2'b11 LRU. Changing `policy` alters no stored state. Only the choice on later misses follows the new setting.
- R9: An access changes only the state of the set it addresses. A cycle with `acc_valid` low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_set | input | $clog2(SETS) | Set index of the access |
| acc_hit | input | 1 | Access hit in the cache |
| acc_way | input | $clog2(WAYS) | Way that hit (used only when acc_hit is 1) |
| policy | input | 2 | Replacement policy select |
| victim_valid | output | 1 | Current access is a miss and victim_way is meaningful |
| victim_way | output | $clog2(WAYS) | Way to fill for the current miss |

## Verification
The bench aims at the orderings where move-to-front is easy to get wrong. A hit deep in the list must shift only the entries above it, so a design that rotated the whole list would then return the wrong least recent way. A hit on the front entry must do nothing, so a design that shifted anyway would disturb the tail. The bench also checks that hits never move the FIFO pointer, that misses under other policies still advance the pointer and the LFSR, and that policy switches and idle cycles keep all history. A design that advanced state only in the active mode, or that leaked an update into a neighbouring set, would return a victim that differs from the behavioural model after the switch.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    typedef enum logic [1:0] {
        POL_LRU     = 2'd0,
        POL_FIFO    = 2'd1,
        POL_RAND    = 2'd2,
        POL_LRU_ALT = 2'd3
    } policy_e;

    localparam int          RNG_W    = 16;
    localparam logic [15:0] RNG_MASK = 16'hB400;
    localparam logic [15:0] RNG_SEED = 16'hACE1;

    function automatic logic [RNG_W-1:0] rng_next(input logic [RNG_W-1:0] s);
        logic [RNG_W-1:0] sh;
        sh = s >> 1;
        return s[0] ? (sh ^ RNG_MASK) : sh;
    endfunction

endpackage

// File: rtl/vsel_lru_store.sv
module vsel_lru_store #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    output logic [WAY_W-1:0] tail_way
);
    logic [WAY_W-1:0] order_q [SETS][WAYS];
    logic [WAY_W-1:0] cur     [WAYS];
    logic [WAY_W-1:0] moved   [WAYS];
    logic [WAYS-1:0]  passed;

    always_comb begin
        for (int i = 0; i < WAYS; i++) cur[i] = order_q[upd_set][i];
    end

    // passed[i]: the touched way sits at a position strictly before i
    assign passed[0] = 1'b0;
    generate
        for (genvar g = 1; g < WAYS; g++) begin : g_scan
            assign passed[g] = passed[g-1] | (cur[g-1] == upd_way);
        end
    endgenerate

    always_comb begin
        moved[0] = upd_way;
        for (int i = 1; i < WAYS; i++) begin
            moved[i] = passed[i] ? cur[i] : cur[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int i = 0; i < WAYS; i++)
                    order_q[s][i] <= WAY_W'(i);
        end else if (upd_en) begin
            for (int i = 0; i < WAYS; i++)
                order_q[upd_set][i] <= moved[i];
        end
    end

    assign tail_way = cur[WAYS-1];

endmodule

// File: rtl/vsel_fifo_store.sv
module vsel_fifo_store #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_en,
    input  logic [SET_W-1:0] sel_set,
    output logic [WAY_W-1:0] ptr_way
);
    logic [WAY_W-1:0] ptr_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (adv_en) begin
            ptr_q[sel_set] <= ptr_q[sel_set] + 1'b1;
        end
    end

    assign ptr_way = ptr_q[sel_set];

endmodule

// File: rtl/vsel_rng.sv
module vsel_rng
    import vsel_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [WAY_W-1:0] pick
);
    logic [RNG_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)       state_q <= RNG_SEED;
        else if (step) state_q <= rng_next(state_q);
    end

    assign pick = state_q[WAY_W-1:0];

endmodule

// File: rtl/victim_selector.sv
module victim_selector
    import vsel_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] acc_way,
    input  logic [1:0]       policy,
    output logic             victim_valid,
    output logic [WAY_W-1:0] victim_way
);
    logic             miss;
    logic [WAY_W-1:0] lru_pick, fifo_pick, rng_pick, touch_way;
    policy_e          pol;

    assign miss = acc_valid & ~acc_hit;
    assign pol  = policy_e'(policy);

    vsel_lru_store #(.WAYS(WAYS), .SETS(SETS)) u_lru (
        .clk(clk), .rst(rst), .upd_en(acc_valid), .upd_set(acc_set),
        .upd_way(touch_way), .tail_way(lru_pick)
    );

    vsel_fifo_store #(.WAYS(WAYS), .SETS(SETS)) u_fifo (
        .clk(clk), .rst(rst), .adv_en(miss), .sel_set(acc_set),
        .ptr_way(fifo_pick)
    );

    vsel_rng #(.WAYS(WAYS)) u_rng (
        .clk(clk), .rst(rst), .step(miss), .pick(rng_pick)
    );

    always_comb begin
        unique case (pol)
            POL_FIFO: victim_way = fifo_pick;
            POL_RAND: victim_way = rng_pick;
            default:  victim_way = lru_pick;
        endcase
    end

    assign touch_way    = acc_hit ? acc_way : victim_way;
    assign victim_valid = miss;

endmodule

// File: rtl/vsel_checker.sv
module vsel_checker #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic [SET_W-1:0] acc_set,
    input logic             acc_hit,
    input logic [WAY_W-1:0] acc_way,
    input logic [1:0]       policy,
    input logic             victim_valid,
    input logic [WAY_W-1:0] victim_way
);
    logic armed_q;
    logic lru_sel, fifo_sel;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    assign lru_sel  = (policy == 2'd0) || (policy == 2'd3);
    assign fifo_sel = (policy == 2'd1);

    // R1: first cycle out of reset, an LRU miss names the last way
    a_r1_reset_tail: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && victim_valid && lru_sel) |-> (victim_way == WAY_W'(WAYS-1)));

    // R4: back-to-back LRU misses to one set never repeat a way
    a_r4_lru_no_repeat: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(victim_valid) && $past(lru_sel) && victim_valid && lru_sel
         && acc_set == $past(acc_set)) |-> (victim_way != $past(victim_way)));

    // R3: a way just hit is never the next LRU victim of that set
    a_r3_hit_not_victim: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(acc_valid) && $past(acc_hit) && victim_valid && lru_sel
         && acc_set == $past(acc_set)) |-> (victim_way != $past(acc_way)));

    // R6: consecutive FIFO misses to one set step the pointer by one
    a_r6_fifo_step: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(victim_valid) && $past(fifo_sel) && victim_valid && fifo_sel
         && acc_set == $past(acc_set)) |-> (victim_way == WAY_W'($past(victim_way) + 1'b1)));

endmodule

bind victim_selector vsel_checker #(.WAYS(WAYS), .SETS(SETS)) u_vsel_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_hit(acc_hit), .acc_way(acc_way), .policy(policy),
    .victim_valid(victim_valid), .victim_way(victim_way)
);

// File: tb/victim_selector_test.sv
module victim_selector_test;
    localparam int CLK_PERIOD = 10;
    localparam int WAYS  = 4;
    localparam int SETS  = 16;
    localparam int WAY_W = $clog2(WAYS);
    localparam int SET_W = $clog2(SETS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             acc_valid = 1'b0;
    logic [SET_W-1:0] acc_set = '0;
    logic             acc_hit = 1'b0;
    logic [WAY_W-1:0] acc_way = '0;
    logic [1:0]       policy = 2'd0;
    logic             victim_valid;
    logic [WAY_W-1:0] victim_way;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int          ord [SETS][WAYS];
    int          fptr[SETS];
    logic [15:0] rng;

    always #(CLK_PERIOD/2) clk = ~clk;

    victim_selector #(.WAYS(WAYS), .SETS(SETS)) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_way(acc_way), .policy(policy),
        .victim_valid(victim_valid), .victim_way(victim_way)
    );

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            for (int i = 0; i < WAYS; i++) ord[s][i] = i;
            fptr[s] = 0;
        end
        rng = 16'hACE1;
    endtask

    function automatic int expected_victim(int s, int p);
        if (p == 1) return fptr[s];
        if (p == 2) return int'(rng) % WAYS;
        return ord[s][WAYS-1];
    endfunction

    task automatic model_update(bit v, int s, bit h, int w, int p);
        int t, pos;
        if (!v) return;
        t = h ? w : expected_victim(s, p);
        pos = WAYS - 1;
        for (int i = 0; i < WAYS; i++) if (ord[s][i] == t) pos = i;
        for (int i = pos; i > 0; i--) ord[s][i] = ord[s][i-1];
        ord[s][0] = t;
        if (!h) begin
            fptr[s] = (fptr[s] + 1) % WAYS;
            rng = rng[0] ? ((rng >> 1) ^ 16'hB400) : (rng >> 1);
        end
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one access, compare combinational outputs, then advance model
    task automatic step(bit v, int s, bit h, int w, int p, string tag);
        @(negedge clk);
        acc_valid = v; acc_set = SET_W'(s); acc_hit = h;
        acc_way = WAY_W'(w); policy = 2'(p);
        #1;
        check({tag, " (R2 valid)"}, int'(victim_valid), (v && !h) ? 1 : 0);
        if (v && !h) check(tag, int'(victim_way), expected_victim(s, p));
        model_update(v, s, h, w, p);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state observed through each policy
        step(0, 0, 0, 0, 0, "R1 idle");
        step(1, 0, 0, 0, 0, "R1 lru tail");
        step(1, 5, 0, 0, 1, "R1 fifo zero");
        step(1, 6, 0, 0, 2, "R1 rng seed");

        // R3: build (0,1,2,3) on set 1, hit 2 -> (2,0,1,3)
        step(1, 1, 1, 3, 0, "R3"); step(1, 1, 1, 2, 0, "R3");
        step(1, 1, 1, 1, 0, "R3"); step(1, 1, 1, 0, 0, "R3");
        step(1, 1, 1, 2, 0, "R3");
        step(1, 1, 0, 0, 0, "R3 tail after deep hit");
        // R4: (1,2,0,3) then miss returns 3
        step(1, 2, 1, 3, 0, "R4"); step(1, 2, 1, 0, 0, "R4");
        step(1, 2, 1, 2, 0, "R4"); step(1, 2, 1, 1, 0, "R4");
        step(1, 2, 0, 0, 0, "R4 miss");
        step(1, 2, 0, 0, 0, "R4 second miss");
        // R5: build (3,1,2,0), hit 3 twice, then miss returns 0
        step(1, 7, 1, 0, 0, "R5"); step(1, 7, 1, 2, 0, "R5");
        step(1, 7, 1, 1, 0, "R5"); step(1, 7, 1, 3, 0, "R5");
        step(1, 7, 1, 3, 0, "R5"); step(1, 7, 1, 3, 0, "R5");
        step(1, 7, 0, 0, 0, "R5 front hit no change");

        // R6: FIFO steps per miss, hits ignored
        for (int k = 0; k < 6; k++) begin
            step(1, 8, 0, 0, 1, "R6 fifo");
            step(1, 8, 1, k % WAYS, 1, "R6 hit");
        end
        step(1, 8, 0, 0, 0, "R6 miss under lru");
        step(1, 8, 0, 0, 1, "R6 pointer after lru miss");

        // R7: random sequence and advance under other policies
        for (int k = 0; k < 8; k++) step(1, 9, 0, 0, 2, "R7 rng");
        step(1, 10, 0, 0, 1, "R7 step under fifo");
        step(1, 9, 0, 0, 2, "R7 rng after fifo miss");

        // R8: policy 3 is LRU, switches keep state
        step(1, 11, 0, 0, 3, "R8 alt lru");
        step(1, 11, 0, 0, 2, "R8 to rng");
        step(1, 11, 0, 0, 1, "R8 to fifo");
        step(1, 11, 0, 0, 0, "R8 back to lru");

        // R9: idle cycles and neighbouring sets
        for (int k = 0; k < 5; k++) step(0, 12, 0, 1, k % 4, "R9 idle");
        step(1, 12, 0, 0, 0, "R9 untouched set");
        step(1, 13, 0, 0, 1, "R9 untouched fifo");

        // mixed traffic across all requirements
        for (int k = 0; k < 3000; k++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, SETS-1),
                 $urandom_range(0, 1) == 1, $urandom_range(0, WAYS-1),
                 $urandom_range(0, 3), "R8 mixed");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule